// File: doc/BRIEF.md
# Packed FP32 to Unsigned 64-bit Converter

This block takes a vector of IEEE-754 single-precision values and turns each selected one into an unsigned 64-bit integer. It produces a 128-, 256- or 512-bit result, so 2, 4 or 8 lanes are active. Lane j of the result takes source element j, or element 0 when broadcast is on.

Each lane has a write-mask bit. A lane that is not written either keeps the value it had in a supplied old-destination vector or is cleared, depending on a merge/zero select.

Rounding follows a global two-bit mode. At full width only, an embedded mode can override it. Two flags report the conversion exceptions of the written lanes: invalid and inexact. The datapath is combinational. A parameter selects one output register stage, and that stage is on by default.

Top module: `fp32ToU64Vec`

## Requirements
- R1: The vector length code selects the active lane count: 2'b00 gives 2 lanes (128 bits), 2'b01 gives 4 lanes (256 bits), and 2'b10 or 2'b11 give 8 lanes (512 bits). Active lane j drives result bits [64j+63:64j] from source bits [32j+31:32j].
- R2: An active lane receives its converted value when masking is disabled (maskEn=0), or when its laneMask bit is 1.
- R3: An active lane whose mask bit is 0 while masking is enabled takes its oldDst lane when zeroMode=0, and 64'h0 when zeroMode=1.
- R4: Every result bit above the selected vector length reads 0, whatever the old-destination vector holds.
- R5: With bcastEn=1, every active lane converts source bits [31:0] and ignores its own element.
- R6: Rounding mode encoding: 2'b00 is nearest-even, 2'b01 is toward minus infinity, 2'b10 is toward plus infinity and 2'b11 is toward zero. An inexact value is rounded to an integer by this rule.
- R7: rcEmbedded replaces roundMode only when the length code selects 512 bits and rcOverride=1. At 128 or 256 bits, rcOverride has no effect.
- R8: These inputs count as unrepresentable: NaN, either infinity, a value that rounds to 2^64 or more, and a negative value that rounds below zero. Such a lane returns 64'hFFFF_FFFF_FFFF_FFFF and raises invalidFlag, and it does not raise inexactFlag.
- R9: A negative value that rounds to zero returns 0 and raises only inexactFlag. Negative zero returns 0 with no flag.
- R10: invalidFlag and inexactFlag are each the OR over the written lanes only. An exact in-range conversion raises neither flag, and lanes that are masked off or inactive never contribute.
- R11: With the output register on, result and flags appear on the clock edge after the inputs are applied. Reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| vecLen | input | 2 | Vector length code (R1) |
| srcVec | input | 256 | Eight packed FP32 source elements |
| oldDst | input | 512 | Previous destination, used for merging |
| laneMask | input | 8 | Per-lane write-mask bits |
| maskEn | input | 1 | 1 = apply laneMask, 0 = write all active lanes |
| zeroMode | input | 1 | 1 = clear masked-off lanes, 0 = keep oldDst |
| bcastEn | input | 1 | Broadcast source element 0 to all lanes |
| roundMode | input | 2 | Global rounding mode |
| rcOverride | input | 1 | Request the embedded rounding mode |
| rcEmbedded | input | 2 | Embedded rounding mode |
| resOut | output | 512 | Packed unsigned 64-bit results |
| invalidFlag | output | 1 | Some written lane was unrepresentable |
| inexactFlag | output | 1 | Some written lane was rounded |

## Verification
Broadcast and write masking can act in the same cycle. When they do, the value fanned out from element 0 must reach only the lanes the mask lets through, and the flags must not count the masked-off copies. The bench provokes this by broadcasting a NaN and then an inexact value with only some mask bits set, in both merge and zero modes. It judges the case by checking that the masked lanes hold the old or zero value exactly and that each flag is set only when a written lane produced it.

// File: rtl/cvtPkg.sv
package cvtPkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rndMode_t;

  typedef enum logic [1:0] {
    VL_QUARTER = 2'b00,
    VL_HALF    = 2'b01,
    VL_FULL    = 2'b10,
    VL_FULL_B  = 2'b11
  } vecLen_t;

  // strobes from control to datapath that are shared by all lanes
  typedef struct packed {
    logic     bcast;
    rndMode_t rmode;
  } ctrlStrobe_t;

  localparam int FP_W    = 32;
  localparam int MAN_W   = 23;
  localparam int EXP_W   = 8;
  localparam int BIAS    = 127;
  localparam int INT_W   = 64;

endpackage

// File: rtl/cvtLaneConv.sv
module cvtLaneConv
  import cvtPkg::*;
(
  input  logic [FP_W-1:0]  fpIn,
  input  rndMode_t         rmode,
  output logic [INT_W-1:0] intOut,
  output logic             invalid,
  output logic             inexact
);

  localparam int SIG_W     = MAN_W + 1;
  localparam int FRAC_EXP  = BIAS + MAN_W;       // exponent where the value is an integer
  localparam int OVF_EXP   = BIAS + INT_W;       // exponent where the value reaches 2^64
  localparam int GRD_W     = SIG_W + 2;          // shift cap: beyond it only sticky remains
  localparam int WIDE_W    = SIG_W + GRD_W;
  localparam int SH_W      = 9;

  logic             sgn;
  logic [EXP_W-1:0] expF;
  logic [MAN_W-1:0] manF;
  logic [SIG_W-1:0] sig;
  logic [SH_W-1:0]  effExp;
  logic             isSpecial;
  logic             tooBig;
  logic             bigPath;
  logic [SH_W-1:0]  lsh;
  logic [SH_W-1:0]  rsh;
  logic [SH_W-1:0]  rshCap;
  logic [WIDE_W-1:0] wide;
  logic [SIG_W-1:0] intPart;
  logic             rndBit;
  logic             stkBit;
  logic             lost;
  logic             inc;
  logic [INT_W-1:0] magBig;
  logic [INT_W-1:0] magSmall;
  logic [INT_W-1:0] mag;
  logic             negNonZero;

  assign sgn    = fpIn[FP_W-1];
  assign expF   = fpIn[FP_W-2 -: EXP_W];
  assign manF   = fpIn[MAN_W-1:0];
  assign sig    = {(expF != '0), manF};
  assign effExp = (expF == '0) ? SH_W'(1) : SH_W'(expF);

  assign isSpecial = &expF;
  assign tooBig    = effExp >= SH_W'(OVF_EXP);
  assign bigPath   = effExp >= SH_W'(FRAC_EXP);

  assign lsh    = effExp - SH_W'(FRAC_EXP);
  assign rsh    = SH_W'(FRAC_EXP) - effExp;
  assign rshCap = (rsh > SH_W'(GRD_W)) ? SH_W'(GRD_W) : rsh;

  assign wide    = {sig, {GRD_W{1'b0}}} >> rshCap;
  assign intPart = wide[WIDE_W-1 -: SIG_W];
  assign rndBit  = wide[GRD_W-1];
  assign stkBit  = |wide[GRD_W-2:0];
  assign lost    = ~bigPath & (rndBit | stkBit);

  always_comb begin
    unique case (rmode)
      RM_NEAR: inc = rndBit & (stkBit | intPart[0]);
      RM_DOWN: inc = sgn & (rndBit | stkBit);
      RM_UP:   inc = ~sgn & (rndBit | stkBit);
      default: inc = 1'b0;
    endcase
  end

  assign magBig   = {{(INT_W-SIG_W){1'b0}}, sig} << lsh;
  assign magSmall = {{(INT_W-SIG_W){1'b0}}, intPart} + {{(INT_W-1){1'b0}}, inc};
  assign mag      = bigPath ? magBig : magSmall;

  assign negNonZero = sgn & (mag != '0);

  always_comb begin
    if (isSpecial || tooBig || negNonZero) begin
      intOut  = '1;
      invalid = 1'b1;
      inexact = 1'b0;
    end else begin
      intOut  = sgn ? '0 : mag;
      invalid = 1'b0;
      inexact = lost;
    end
  end

endmodule

// File: rtl/cvtControl.sv
module cvtControl
  import cvtPkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [1:0]       vecLen,
  input  logic [LANES-1:0] laneMask,
  input  logic             maskEn,
  input  logic             zeroMode,
  input  logic             bcastEn,
  input  logic [1:0]       roundMode,
  input  logic             rcOverride,
  input  logic [1:0]       rcEmbedded,
  output logic [LANES-1:0] laneWrite,
  output logic [LANES-1:0] laneKeep,
  output ctrlStrobe_t      strobe
);

  localparam int CNT_W = $clog2(LANES + 1);

  logic [CNT_W-1:0] activeCnt;
  logic             fullWidth;
  logic [LANES-1:0] laneActive;

  always_comb begin
    unique case (vecLen_t'(vecLen))
      VL_QUARTER: activeCnt = CNT_W'(LANES / 4);
      VL_HALF:    activeCnt = CNT_W'(LANES / 2);
      default:    activeCnt = CNT_W'(LANES);
    endcase
  end

  assign fullWidth = vecLen[1];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign laneActive[j] = CNT_W'(j) < activeCnt;
    assign laneWrite[j]  = laneActive[j] & (~maskEn | laneMask[j]);
    assign laneKeep[j]   = laneActive[j] & maskEn & ~laneMask[j] & ~zeroMode;
  end

  assign strobe.bcast = bcastEn;
  assign strobe.rmode = (fullWidth && rcOverride) ? rndMode_t'(rcEmbedded)
                                                  : rndMode_t'(roundMode);

endmodule

// File: rtl/cvtDatapath.sv
module cvtDatapath
  import cvtPkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [LANES*FP_W-1:0]  srcVec,
  input  logic [LANES*INT_W-1:0] oldDst,
  input  logic [LANES-1:0]       laneWrite,
  input  logic [LANES-1:0]       laneKeep,
  input  ctrlStrobe_t            strobe,
  output logic [LANES*INT_W-1:0] resComb,
  output logic                   invalidComb,
  output logic                   inexactComb
);

  logic [LANES-1:0] laneInv;
  logic [LANES-1:0] laneInx;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [FP_W-1:0]  laneSrc;
    logic [INT_W-1:0] laneConv;
    logic             convInv;
    logic             convInx;

    assign laneSrc = strobe.bcast ? srcVec[FP_W-1:0] : srcVec[FP_W*j +: FP_W];

    cvtLaneConv u_conv (
      .fpIn    (laneSrc),
      .rmode   (strobe.rmode),
      .intOut  (laneConv),
      .invalid (convInv),
      .inexact (convInx)
    );

    always_comb begin
      if (laneWrite[j])     resComb[INT_W*j +: INT_W] = laneConv;
      else if (laneKeep[j]) resComb[INT_W*j +: INT_W] = oldDst[INT_W*j +: INT_W];
      else                  resComb[INT_W*j +: INT_W] = '0;
    end

    assign laneInv[j] = laneWrite[j] & convInv;
    assign laneInx[j] = laneWrite[j] & convInx;
  end

  assign invalidComb = |laneInv;
  assign inexactComb = |laneInx;

endmodule

// File: rtl/fp32ToU64Vec.sv
module fp32ToU64Vec
  import cvtPkg::*;
#(
  parameter int LANES   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             vecLen,
  input  logic [LANES*FP_W-1:0]  srcVec,
  input  logic [LANES*INT_W-1:0] oldDst,
  input  logic [LANES-1:0]       laneMask,
  input  logic                   maskEn,
  input  logic                   zeroMode,
  input  logic                   bcastEn,
  input  logic [1:0]             roundMode,
  input  logic                   rcOverride,
  input  logic [1:0]             rcEmbedded,
  output logic [LANES*INT_W-1:0] resOut,
  output logic                   invalidFlag,
  output logic                   inexactFlag
);

  localparam int DST_W     = LANES * INT_W;
  localparam int QUARTER_W = DST_W / 4;

  logic [LANES-1:0]  laneWrite;
  logic [LANES-1:0]  laneKeep;
  ctrlStrobe_t       strobe;
  logic [DST_W-1:0]  resComb;
  logic              invalidComb;
  logic              inexactComb;

  cvtControl #(.LANES(LANES)) u_ctrl (
    .vecLen     (vecLen),
    .laneMask   (laneMask),
    .maskEn     (maskEn),
    .zeroMode   (zeroMode),
    .bcastEn    (bcastEn),
    .roundMode  (roundMode),
    .rcOverride (rcOverride),
    .rcEmbedded (rcEmbedded),
    .laneWrite  (laneWrite),
    .laneKeep   (laneKeep),
    .strobe     (strobe)
  );

  cvtDatapath #(.LANES(LANES)) u_dp (
    .srcVec      (srcVec),
    .oldDst      (oldDst),
    .laneWrite   (laneWrite),
    .laneKeep    (laneKeep),
    .strobe      (strobe),
    .resComb     (resComb),
    .invalidComb (invalidComb),
    .inexactComb (inexactComb)
  );

  if (OUT_REG) begin : g_reg
    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        resOut      <= '0;
        invalidFlag <= 1'b0;
        inexactFlag <= 1'b0;
        primed      <= 1'b0;
      end else begin
        resOut      <= resComb;
        invalidFlag <= invalidComb;
        inexactFlag <= inexactComb;
        primed      <= 1'b1;
      end
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(vecLen) == 2'b00) |-> resOut[DST_W-1:QUARTER_W] == '0); // R4

    AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(maskEn) && !$past(laneMask[0]) && !$past(zeroMode))
        |-> resOut[INT_W-1:0] == $past(oldDst[INT_W-1:0])); // R3

    AST_ZERO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(maskEn) && !$past(laneMask[0]) && $past(zeroMode))
        |-> resOut[INT_W-1:0] == '0); // R3

    AST_NAN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !$past(maskEn) && (&$past(srcVec[FP_W-2 -: EXP_W])))
        |-> (resOut[INT_W-1:0] == '1) && invalidFlag); // R8

    AST_MASKED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(maskEn) && $past(laneMask) == '0)
        |-> !invalidFlag && !inexactFlag); // R10

  end else begin : g_comb
    assign resOut      = resComb;
    assign invalidFlag = invalidComb;
    assign inexactFlag = inexactComb;
  end

endmodule

// File: tb/fp32ToU64Vec_tb.sv
module fp32ToU64Vec_tb;

  localparam int LANES = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   vecLen = 2'b10;
  logic [255:0] srcVec = '0;
  logic [511:0] oldDst = '0;
  logic [7:0]   laneMask = '0;
  logic         maskEn = 1'b0;
  logic         zeroMode = 1'b0;
  logic         bcastEn = 1'b0;
  logic [1:0]   roundMode = 2'b00;
  logic         rcOverride = 1'b0;
  logic [1:0]   rcEmbedded = 2'b00;
  logic [511:0] resOut;
  logic         invalidFlag;
  logic         inexactFlag;

  always #2 clk = ~clk;

  fp32ToU64Vec #(.LANES(LANES), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .vecLen(vecLen), .srcVec(srcVec), .oldDst(oldDst),
    .laneMask(laneMask), .maskEn(maskEn), .zeroMode(zeroMode), .bcastEn(bcastEn),
    .roundMode(roundMode), .rcOverride(rcOverride), .rcEmbedded(rcEmbedded),
    .resOut(resOut), .invalidFlag(invalidFlag), .inexactFlag(inexactFlag)
  );

  typedef struct {
    logic [511:0] res;
    logic         inv;
    logic         inx;
    string        tag;
    int           stamp;
  } item_t;

  item_t expQ[$];
  int    cyc = 0;
  int    chkCnt = 0;
  int    errCnt = 0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference conversion worked out with real arithmetic
  task automatic refConv(input logic [31:0] f, input logic [1:0] rm,
                         output logic [63:0] val, output logic inv, output logic inx);
    logic       s;
    int         e;
    logic [23:0] sg;
    real        v;
    real        fl;
    real        fr;
    logic       up;
    longint unsigned mag;
    s  = f[31];
    e  = int'(f[30:23]);
    sg = {(e != 0), f[22:0]};
    inv = 1'b0;
    inx = 1'b0;
    val = 64'd0;
    if (e == 255 || e >= 191) begin
      inv = 1'b1;
      val = '1;
    end else if (e >= 150) begin
      mag = longint'(sg) << (e - 150);
      if (s) begin inv = 1'b1; val = '1; end
      else val = mag;
    end else begin
      v = real'(sg);
      for (int k = 0; k < 150 - ((e == 0) ? 1 : e); k++) v = v / 2.0;
      fl = $floor(v);
      fr = v - fl;
      case (rm)
        2'b00: up = (fr > 0.5) || (fr == 0.5 && ($rtoi(fl) % 2 == 1));
        2'b01: up = s && (fr > 0.0);
        2'b10: up = !s && (fr > 0.0);
        default: up = 1'b0;
      endcase
      mag = longint'($rtoi(fl)) + (up ? 64'd1 : 64'd0);
      if (s && mag != 0) begin inv = 1'b1; val = '1; end
      else begin val = s ? 64'd0 : mag; inx = (fr > 0.0); end
    end
  endtask

  // drive current inputs' expectation into the scoreboard
  task automatic pushExp(input string tag);
    item_t it;
    int act;
    logic [1:0] rm;
    logic [63:0] lv;
    logic li, lx;
    act = (vecLen == 2'b00) ? 2 : (vecLen == 2'b01) ? 4 : 8;
    rm  = (vecLen[1] && rcOverride) ? rcEmbedded : roundMode;
    it.res = '0; it.inv = 1'b0; it.inx = 1'b0;
    for (int j = 0; j < act; j++) begin
      if (!maskEn || laneMask[j]) begin
        refConv(bcastEn ? srcVec[31:0] : srcVec[32*j +: 32], rm, lv, li, lx);
        it.res[64*j +: 64] = lv;
        it.inv |= li;
        it.inx |= lx;
      end else if (!zeroMode) begin
        it.res[64*j +: 64] = oldDst[64*j +: 64];
      end
    end
    it.tag = tag;
    it.stamp = cyc;
    expQ.push_back(it);
  endtask

  // monitor: results appear one edge after the driving negedge
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].stamp < cyc) begin
      item_t it;
      it = expQ.pop_front();
      chkCnt++;
      if (resOut !== it.res) begin
        errCnt++;
        $display("FAIL %s result: got %h expected %h", it.tag, resOut, it.res);
      end
      chkCnt++;
      if (invalidFlag !== it.inv || inexactFlag !== it.inx) begin
        errCnt++;
        $display("FAIL %s flags inv/inx: got %b%b expected %b%b", it.tag,
                 invalidFlag, inexactFlag, it.inv, it.inx);
      end
    end
  end

  task automatic step(input string tag);
    pushExp(tag);
    @(negedge clk);
  endtask

  task automatic setAll(input logic [31:0] f);
    for (int j = 0; j < 8; j++) srcVec[32*j +: 32] = f;
  endtask

  initial begin
    for (int j = 0; j < 8; j++) oldDst[64*j +: 64] = {32'hA5A5_0000, 32'(j)};
    srcVec = {8{32'h3F80_0000}};
    repeat (3) @(negedge clk);
    chkCnt++;
    if (resOut !== '0 || invalidFlag !== 1'b0 || inexactFlag !== 1'b0) begin
      errCnt++;
      $display("FAIL R11 reset: got %h %b%b expected 0", resOut, invalidFlag, inexactFlag);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R6: full width, mixed values, nearest-even
    srcVec = {32'h42C8_0000, 32'h3FD9_999A, 32'h4060_0000, 32'h4020_0000,
              32'h3F00_0000, 32'h3FC0_0000, 32'h5F7F_FFFF, 32'h3F80_0000};
    step("R1_R6_near");
    for (int m = 1; m < 4; m++) begin
      roundMode = 2'(m);
      step("R6_modes");
    end
    // R9: negative small values
    roundMode = 2'b11;
    srcVec = {32'h8000_0000, 32'hBE99_999A, 32'h0000_0001, 32'hBE99_999A,
              32'h8000_0000, 32'hBE99_999A, 32'h0000_0001, 32'hBE99_999A};
    step("R9_negzero");
    roundMode = 2'b00;
    step("R9_near");
    roundMode = 2'b10;
    step("R9_up_denorm");
    roundMode = 2'b01;
    step("R8_down_neg");
    // R8: specials and range edges
    roundMode = 2'b00;
    srcVec = {32'h7FC0_0000, 32'h7F80_0000, 32'hFF80_0000, 32'h5F80_0000,
              32'h5F00_0000, 32'hBF80_0000, 32'hC020_0000, 32'h4F80_0000};
    step("R8_specials");
    // R7: override at full width vs. narrower
    srcVec = {8{32'h4020_0000}};
    rcOverride = 1'b1; rcEmbedded = 2'b10;
    vecLen = 2'b10; step("R7_full_override");
    vecLen = 2'b11; step("R7_code11_override");
    vecLen = 2'b01; step("R7_half_ignored");
    vecLen = 2'b00; step("R7_quarter_ignored");
    rcOverride = 1'b0;
    // R4: upper bits cleared although oldDst is full
    vecLen = 2'b00; maskEn = 1'b1; laneMask = 8'h00; zeroMode = 1'b0;
    step("R4_quarter_merge");
    vecLen = 2'b01; laneMask = 8'hF5; step("R4_half_merge");
    maskEn = 1'b0;
    // R2 R3: masking
    vecLen = 2'b10; srcVec = {32'h42C8_0000, 32'h3FD9_999A, 32'h4060_0000, 32'h4020_0000,
                              32'h3F00_0000, 32'h3FC0_0000, 32'h5F7F_FFFF, 32'h3F80_0000};
    maskEn = 1'b1; laneMask = 8'hA5; zeroMode = 1'b0; step("R2_R3_merge");
    zeroMode = 1'b1; step("R3_zero");
    laneMask = 8'hFF; step("R2_all_set");
    // R10: unrepresentable and inexact lanes only where masked off
    setAll(32'h3F80_0000);
    srcVec[32*3 +: 32] = 32'h7FC0_0000;
    srcVec[32*6 +: 32] = 32'h3FD9_999A;
    laneMask = 8'hB7; step("R10_masked_flags");
    laneMask = 8'h00; step("R10_none_written");
    // R5 with masking in the same cycle
    maskEn = 1'b1; bcastEn = 1'b1; srcVec[31:0] = 32'h7FC0_0000;
    laneMask = 8'h3C; zeroMode = 1'b0; step("R5_bcast_nan_merge");
    srcVec[31:0] = 32'h3FD9_999A; zeroMode = 1'b1; step("R5_bcast_inexact_zero");
    laneMask = 8'h00; step("R5_R10_bcast_nomask");
    maskEn = 1'b0; srcVec[31:0] = 32'h4060_0000; vecLen = 2'b01; step("R5_bcast_half");
    bcastEn = 1'b0;
    // R11: back-to-back changes each show one edge later
    vecLen = 2'b10; setAll(32'h4020_0000); step("R11_seq_a");
    setAll(32'h42C8_0000); step("R11_seq_b");
    repeat (3) @(negedge clk);
    chkCnt++;
    if (expQ.size() != 0) begin
      errCnt++;
      $display("FAIL R11 scoreboard drain: got %0d left expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      chkCnt++;
      errCnt++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

endmodule